// File: doc/BRIEF.md
# Dual-Set Fetch Scheduler with Backward-Branch Parking

This block picks, each cycle, which program counter a shared instruction-fetch front end serves for a group of hardware threads. Threads are partitioned into two sets: a *current* set that competes for fetch and a *future* set that waits. Among the active threads in the current set, the lowest PC wins, and every current thread sitting at that PC shares the fetched instruction.

A thread that shares a fetch and reports a taken branch whose target is not above its own PC has looped back. It is moved into the future set, so it cannot race ahead of its peers that are still inside the loop body. Threads that leave the loop stay current and keep running. Once no active thread is left in the current set, the sets trade roles. The swap costs one cycle in which nothing is fetched. Finished threads are removed from both sets.

The surrounding core supplies each thread's PC, an active flag, and a per-thread report for the instruction that thread is executing this cycle: a taken flag and the next PC. The block returns the fetch PC, a participation mask and a per-thread view of which set each thread belongs to.

Top module: `dual_set_fetch_sched`

## Requirements
- R1: After reset, every active thread is in the current set (`cur_mask` equals `thr_active`) and `fut_mask` is zero.
- R2: When at least one active thread is in the current set, `fetch_valid` is 1 in the same cycle and `fetch_pc` is the smallest PC among those threads.
- R3: `fetch_mask` has bit i set exactly when thread i is active, is in the current set and has the PC equal to `fetch_pc`. A future-set thread is never served while the current set is non-empty, even if its PC is lower.
- R4: A thread in `fetch_mask` that reports `br_taken` with a next PC less than or equal to its own PC (equal counts as backward) shows in `fut_mask` from the next cycle on.
- R5: A thread in `fetch_mask` that reports `br_taken` with a next PC greater than its own PC stays in the current set.
- R6: A `br_taken` report from a thread that is not in `fetch_mask` leaves that thread's set membership unchanged.
- R7: In a cycle where no active thread is in the current set but some are in the future set, `fetch_valid` is 0, `fetch_mask` is zero and `fetch_pc` is zero. In the next cycle, all those threads are in the current set and `fut_mask` is zero.
- R8: An inactive thread appears in neither `cur_mask` nor `fut_mask`. Its future membership is cleared, so when it becomes active again it is in the current set.
- R9: With no active thread, `fetch_valid` is 0, `fetch_mask` is zero and `fetch_pc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_active | input | N_THREADS | Thread i is alive (not finished) |
| thr_pc | input | N_THREADS*PC_W | Current PC of each thread, thread i at bits [i*PC_W +: PC_W] |
| br_taken | input | N_THREADS | Thread i's executing instruction is a taken branch |
| br_next_pc | input | N_THREADS*PC_W | Branch target of each thread, same packing as thr_pc |
| fetch_valid | output | 1 | A fetch is issued this cycle |
| fetch_pc | output | PC_W | PC to fetch, zero when no fetch |
| fetch_mask | output | N_THREADS | Threads that receive the fetched instruction |
| cur_mask | output | N_THREADS | Active threads in the current set |
| fut_mask | output | N_THREADS | Active threads in the future set |

## Verification
Fetch outputs (`fetch_valid`, `fetch_pc`, `fetch_mask`) and both membership masks are combinational in the present inputs and the stored set bits, so they are due in the same cycle as the stimulus. A set change caused by a branch report, a swap or a deactivation is due one clock edge later. The bench drives every input on the falling edge and samples all outputs 1 ns later. It then advances its reference set model past the next rising edge, so a membership effect is checked in the sample that follows the edge that stores it. Directed steps cover the equal-PC backward case, ignored reports, forward branches, the empty-cycle swap and re-activation. A seeded random phase with a narrow PC range forces frequent ties and swaps.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    localparam int unsigned DSF_DEF_THREADS = 4;
    localparam int unsigned DSF_DEF_PC_W    = 16;
    localparam int unsigned DSF_CMP_W       = 64;

    // What the front end does this cycle
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // nobody active
        PH_RUN  = 2'd1,   // current set non-empty: fetch
        PH_SWAP = 2'd2    // current drained, future waiting: exchange roles
    } dsf_phase_e;

    // A taken branch whose target is not above its own address loops back
    function automatic logic dsf_loops_back(input logic [DSF_CMP_W-1:0] from_pc,
                                            input logic [DSF_CMP_W-1:0] to_pc);
        return to_pc <= from_pc;
    endfunction

endpackage

// File: rtl/dsf_min_pc.sv
module dsf_min_pc #(
    parameter int unsigned N_THREADS = 4,
    parameter int unsigned PC_W      = 16
) (
    input  logic [N_THREADS-1:0]      cand,
    input  logic [N_THREADS*PC_W-1:0] pcs,
    output logic                      found,
    output logic [PC_W-1:0]           min_pc
);

    logic [N_THREADS:0]           seen;
    logic [N_THREADS:0][PC_W-1:0] best;

    assign seen[0] = 1'b0;
    assign best[0] = '0;

    // Linear running minimum over the candidate threads
    for (genvar k = 0; k < N_THREADS; k++) begin : g_stage
        logic [PC_W-1:0] this_pc;
        logic            take;
        assign this_pc     = pcs[k*PC_W +: PC_W];
        assign take        = cand[k] && (!seen[k] || (this_pc < best[k]));
        assign best[k+1]   = take ? this_pc : best[k];
        assign seen[k+1]   = seen[k] | cand[k];
    end

    assign found  = seen[N_THREADS];
    assign min_pc = best[N_THREADS];

endmodule

// File: rtl/dsf_member_slot.sv
module dsf_member_slot
    import dsf_pkg::*;
#(
    parameter int unsigned PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            granted,
    input  logic            taken,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [PC_W-1:0] next_pc,
    input  logic            swap,
    output logic            in_future
);

    logic parks;

    assign parks = granted && taken &&
                   dsf_loops_back(DSF_CMP_W'(cur_pc), DSF_CMP_W'(next_pc));

    always_ff @(posedge clk) begin
        if (rst) begin
            in_future <= 1'b0;
        end else if (!active) begin
            in_future <= 1'b0;          // finished: out of both sets
        end else if (swap) begin
            in_future <= 1'b0;          // waiting set becomes the running set
        end else if (parks) begin
            in_future <= 1'b1;
        end
    end

endmodule

// File: rtl/dual_set_fetch_sched.sv
module dual_set_fetch_sched
    import dsf_pkg::*;
#(
    parameter int unsigned N_THREADS = DSF_DEF_THREADS,
    parameter int unsigned PC_W      = DSF_DEF_PC_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_THREADS-1:0]      thr_active,
    input  logic [N_THREADS*PC_W-1:0] thr_pc,
    input  logic [N_THREADS-1:0]      br_taken,
    input  logic [N_THREADS*PC_W-1:0] br_next_pc,
    output logic                      fetch_valid,
    output logic [PC_W-1:0]           fetch_pc,
    output logic [N_THREADS-1:0]      fetch_mask,
    output logic [N_THREADS-1:0]      cur_mask,
    output logic [N_THREADS-1:0]      fut_mask
);

    logic [N_THREADS-1:0] fut_bit;
    logic                 any_cur;
    logic [PC_W-1:0]      low_pc;
    dsf_phase_e           phase;
    logic                 swap;

    assign cur_mask = thr_active & ~fut_bit;
    assign fut_mask = thr_active & fut_bit;

    dsf_min_pc #(
        .N_THREADS (N_THREADS),
        .PC_W      (PC_W)
    ) u_min (
        .cand   (cur_mask),
        .pcs    (thr_pc),
        .found  (any_cur),
        .min_pc (low_pc)
    );

    always_comb begin
        if (any_cur)
            phase = PH_RUN;
        else if (|fut_mask)
            phase = PH_SWAP;
        else
            phase = PH_IDLE;
    end

    assign swap        = (phase == PH_SWAP);
    assign fetch_valid = (phase == PH_RUN);
    assign fetch_pc    = fetch_valid ? low_pc : '0;

    for (genvar g = 0; g < N_THREADS; g++) begin : g_thr
        assign fetch_mask[g] = fetch_valid && cur_mask[g] &&
                               (thr_pc[g*PC_W +: PC_W] == low_pc);

        dsf_member_slot #(
            .PC_W (PC_W)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .active    (thr_active[g]),
            .granted   (fetch_mask[g]),
            .taken     (br_taken[g]),
            .cur_pc    (thr_pc[g*PC_W +: PC_W]),
            .next_pc   (br_next_pc[g*PC_W +: PC_W]),
            .swap      (swap),
            .in_future (fut_bit[g])
        );
    end

endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
    parameter int unsigned N_THREADS = 4,
    parameter int unsigned PC_W      = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic [N_THREADS-1:0]      thr_active,
    input logic [N_THREADS*PC_W-1:0] thr_pc,
    input logic [N_THREADS-1:0]      br_taken,
    input logic [N_THREADS*PC_W-1:0] br_next_pc,
    input logic                      fetch_valid,
    input logic [PC_W-1:0]           fetch_pc,
    input logic [N_THREADS-1:0]      fetch_mask,
    input logic [N_THREADS-1:0]      cur_mask,
    input logic [N_THREADS-1:0]      fut_mask
);

    a_r2_valid_tracks_current: assert property (@(posedge clk) disable iff (rst)
        fetch_valid == (cur_mask != '0));

    a_r3_mask_within_current: assert property (@(posedge clk) disable iff (rst)
        (fetch_mask & ~cur_mask) == '0);

    a_r7_swap_no_fetch: assert property (@(posedge clk) disable iff (rst)
        (cur_mask == '0 && fut_mask != '0) |-> (!fetch_valid && fetch_mask == '0));

    a_r7_swap_empties_future: assert property (@(posedge clk) disable iff (rst)
        (cur_mask == '0 && fut_mask != '0) |=> (fut_mask == '0));

    a_r8_inactive_in_no_set: assert property (@(posedge clk) disable iff (rst)
        ((cur_mask | fut_mask) & ~thr_active) == '0);

    a_r9_idle_no_fetch: assert property (@(posedge clk) disable iff (rst)
        (thr_active == '0) |-> (!fetch_valid && fetch_mask == '0 && fetch_pc == '0));

    for (genvar i = 0; i < N_THREADS; i++) begin : g_per
        a_r3_mask_at_fetch_pc: assert property (@(posedge clk) disable iff (rst)
            fetch_mask[i] |-> (thr_pc[i*PC_W +: PC_W] == fetch_pc));

        a_r4_backward_parks: assert property (@(posedge clk) disable iff (rst)
            (fetch_mask[i] && br_taken[i] &&
             br_next_pc[i*PC_W +: PC_W] <= thr_pc[i*PC_W +: PC_W])
            |=> (fut_mask[i] || !thr_active[i]));

        a_r6_unserved_report_ignored: assert property (@(posedge clk) disable iff (rst)
            (!fetch_mask[i] && cur_mask != '0 && thr_active[i])
            |=> ((fut_mask[i] == $past(fut_mask[i])) || !thr_active[i]));
    end

endmodule

bind dual_set_fetch_sched dsf_checker #(
    .N_THREADS (N_THREADS),
    .PC_W      (PC_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .thr_active  (thr_active),
    .thr_pc      (thr_pc),
    .br_taken    (br_taken),
    .br_next_pc  (br_next_pc),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .fetch_mask  (fetch_mask),
    .cur_mask    (cur_mask),
    .fut_mask    (fut_mask)
);

// File: tb/dual_set_fetch_sched_tb.sv
`timescale 1ns/1ps
module dual_set_fetch_sched_tb;

    localparam int NT = 4;
    localparam int PW = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic [NT-1:0]     thr_active;
    logic [NT*PW-1:0]  thr_pc;
    logic [NT-1:0]     br_taken;
    logic [NT*PW-1:0]  br_next_pc;
    logic              fetch_valid;
    logic [PW-1:0]     fetch_pc;
    logic [NT-1:0]     fetch_mask;
    logic [NT-1:0]     cur_mask;
    logic [NT-1:0]     fut_mask;

    always #2.5 clk = ~clk;

    dual_set_fetch_sched #(.N_THREADS(NT), .PC_W(PW)) u_dut (
        .clk(clk), .rst(rst), .thr_active(thr_active), .thr_pc(thr_pc),
        .br_taken(br_taken), .br_next_pc(br_next_pc), .fetch_valid(fetch_valid),
        .fetch_pc(fetch_pc), .fetch_mask(fetch_mask), .cur_mask(cur_mask),
        .fut_mask(fut_mask)
    );

    int n_total = 0;
    int n_bad   = 0;

    // stimulus for the next step
    logic [NT-1:0] act_v, br_v;
    logic [PW-1:0] pc_a [NT];
    logic [PW-1:0] nx_a [NT];
    // reference future-set bits
    logic [NT-1:0] m_fut;
    // last sampled outputs
    logic          s_valid;
    logic [PW-1:0] s_pc;
    logic [NT-1:0] s_mask, s_cur, s_fut;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_total++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [PW-1:0] ref_min(input logic [NT-1:0] set);
        logic [PW-1:0] m = '1;
        for (int i = 0; i < NT; i++)
            if (set[i] && pc_a[i] < m) m = pc_a[i];
        return m;
    endfunction

    task automatic step();
        logic [NT-1:0] ec, ef, em;
        logic          ev;
        logic [PW-1:0] ep;
        string         vt;
        @(negedge clk);
        thr_active = act_v;
        br_taken   = br_v;
        for (int i = 0; i < NT; i++) begin
            thr_pc[i*PW +: PW]     = pc_a[i];
            br_next_pc[i*PW +: PW] = nx_a[i];
        end
        #1;
        ec = act_v & ~m_fut;
        ef = act_v & m_fut;
        ev = (ec != '0);
        ep = ev ? ref_min(ec) : '0;
        em = '0;
        if (ev)
            for (int i = 0; i < NT; i++) em[i] = ec[i] && (pc_a[i] == ep);
        vt = ev ? "R2" : ((ef != '0) ? "R7" : "R9");
        chk(vt, 32'(fetch_valid), 32'(ev));
        chk(vt, 32'(fetch_pc), 32'(ep));
        chk("R3", 32'(fetch_mask), 32'(em));
        chk("R8", 32'(cur_mask), 32'(ec));
        chk("R8", 32'(fut_mask), 32'(ef));
        s_valid = fetch_valid; s_pc = fetch_pc; s_mask = fetch_mask;
        s_cur = cur_mask; s_fut = fut_mask;
        // reference update for the coming edge
        if (!ev) m_fut = '0;
        else
            for (int i = 0; i < NT; i++) begin
                if (!act_v[i]) m_fut[i] = 1'b0;
                else if (em[i] && br_v[i] && nx_a[i] <= pc_a[i]) m_fut[i] = 1'b1;
            end
    endtask

    task automatic set_pcs(input int a, input int b, input int c, input int d);
        pc_a[0] = PW'(a); pc_a[1] = PW'(b); pc_a[2] = PW'(c); pc_a[3] = PW'(d);
    endtask

    task automatic set_nx(input int a, input int b, input int c, input int d);
        nx_a[0] = PW'(a); nx_a[1] = PW'(b); nx_a[2] = PW'(c); nx_a[3] = PW'(d);
    endtask

    initial begin
        #500000;
        n_total++; n_bad++;
        $display("FAIL watchdog: got=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        thr_active = '1; thr_pc = '0; br_taken = '0; br_next_pc = '0;
        m_fut = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state, all alive threads current
        act_v = 4'hF; br_v = '0; set_pcs(10, 10, 10, 10); set_nx(0, 0, 0, 0);
        step();
        chk("R1", 32'(s_cur), 32'hF);
        chk("R1", 32'(s_fut), 32'h0);
        chk("R2", 32'(s_pc), 32'd10);

        // threads 0,1 at 5 served; 0 jumps back, 1 jumps to itself; 2 reports but is unserved
        set_pcs(5, 5, 9, 9); set_nx(2, 5, 1, 9); br_v = 4'b0111;
        step();
        chk("R3", 32'(s_mask), 32'h3);

        // parked threads at a lower PC must not be served
        set_pcs(2, 2, 9, 9); set_nx(0, 0, 12, 4); br_v = 4'b1101;
        step();
        chk("R4", 32'(s_fut), 32'h3);
        chk("R6", 32'(s_cur), 32'hC);
        chk("R3", 32'(s_mask), 32'hC);
        chk("R3", 32'(s_pc), 32'd9);

        // thread 2 went forward, thread 3 looped back
        set_pcs(2, 2, 12, 4); set_nx(0, 0, 0, 0); br_v = '0;
        step();
        chk("R5", 32'(s_cur), 32'h4);
        chk("R4", 32'(s_fut), 32'hB);

        // thread 2 finishes: current drains, swap cycle
        act_v = 4'b1011;
        step();
        chk("R7", 32'(s_valid), 32'h0);
        chk("R7", 32'(s_mask), 32'h0);
        chk("R7", 32'(s_pc), 32'h0);

        step();
        chk("R7", 32'(s_cur), 32'hB);
        chk("R7", 32'(s_fut), 32'h0);
        chk("R2", 32'(s_pc), 32'd2);

        // thread 0 parks, then dies, then returns in the current set
        act_v = 4'hF; set_pcs(2, 3, 12, 4); set_nx(1, 0, 0, 0); br_v = 4'b0001;
        step();
        br_v = '0; act_v = 4'b1110;
        step();
        chk("R8", 32'(s_fut), 32'h0);
        act_v = 4'hF;
        step();
        chk("R8", 32'(s_cur), 32'hF);

        // R9: nobody alive
        act_v = '0;
        step();
        chk("R9", 32'(s_valid), 32'h0);
        chk("R9", 32'(s_mask), 32'h0);

        // seeded random traffic, narrow PC range for ties and frequent swaps
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < NT; i++) begin
                act_v[i] = ($urandom_range(0, 15) != 0);
                br_v[i]  = ($urandom_range(0, 2) == 0);
                pc_a[i]  = PW'($urandom_range(0, 7));
                nx_a[i]  = PW'($urandom_range(0, 7));
            end
            step();
        end

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule